// File: doc/BRIEF.md
# Host Command/Data Mailbox Channel

This block is a single byte-wide mailbox between an external host bus and a local processor. The host side sees an already decoded I/O cycle: a strobe, a write flag, a 16-bit address and a byte of write data. The local side sees a small register port with a select, read and write strobes and a combinational read-back bus.

The host writes bytes into an inbound register and reads bytes back either from an outbound register or from a status byte. Address bit 2 plays two roles. On a host write it is stored as a command/data marker. On a host read it chooses between the outbound register and the status byte. The channel answers only when the host address matches a programmable base address. Bit 2 takes no part in that match.

Two handshake flags in the status byte tell each side when the other has left a byte waiting. There is no queue behind either register, so a later host write replaces an earlier byte that has not yet been read.

Top module: `host_mailbox`

## Requirements
- R1: After reset the inbound register, the outbound register and the status byte all read 0x00.
- R2: A host cycle hits the channel when hostAddr[15:3] equals baseAddr[15:3] and hostAddr[1:0] equals baseAddr[1:0]. hostAddr[2] takes no part in the match.
- R3: A host write that hits stores hostWdata into the inbound register. This happens even when the inbound flag is already set: the old byte is overwritten and nothing is queued.
- R4: A host write that hits copies hostAddr[2] into status bit 3, where 1 marks a command and 0 marks data.
- R5: A host read that hits raises hostRdValid in the same cycle. It returns the outbound register when hostAddr[2] is 0 and the status byte when hostAddr[2] is 1.
- R6: Status bit 1 (inbound full) is set by a host write that hits. It is cleared by a local read strobe with locSel=0. When both happen in the same cycle, the set wins.
- R7: Status bit 0 (outbound full) is set by a local write with locSel=1, which also loads locWdata into the outbound register. It is cleared by a host read of the outbound register and not by a host read of the status byte. When the set and the clear happen in the same cycle, the set wins.
- R8: A host cycle that misses leaves hostRdValid low and hostRdata at 0x00, and changes no register or flag.
- R9: locRdata shows the inbound register for locSel=0, the outbound register for locSel=1, the status byte for locSel=2 and 0x00 for locSel=3. A local write with locSel other than 1 has no effect. Status bits 7:4 and bit 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 16 | Programmed channel base address |
| hostStb | input | 1 | Host I/O cycle strobe, one cycle per access |
| hostWr | input | 1 | 1 = host write, 0 = host read |
| hostAddr | input | 16 | Host I/O address |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, 0x00 when not answering |
| hostRdValid | output | 1 | Channel is answering a host read |
| locSel | input | 2 | Local register select |
| locRd | input | 1 | Local read strobe (clears inbound flag for select 0) |
| locWr | input | 1 | Local write strobe |
| locWdata | input | 8 | Local write byte |
| locRdata | output | 8 | Local read-back byte |

## Verification
Host writes are sent with address bit 2 both clear and set. This shows that the command/data marker follows the address and not the data, and a back-to-back pair shows that a second write overwrites the first. Host reads are sent to both bit-2 addresses while the outbound flag is set, which separates the clear caused by an outbound read from the status read that must leave the flag alone. Addresses that differ from the base only in bits 1:0, only in bit 3 or only in upper bits confirm the full match. A second base value shows that the decode follows the input. Same-cycle set and clear pairs on both flags show which one wins.

// File: rtl/host_mailbox_pkg.sv
package host_mailbox_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CD  = 3;

  localparam logic [SEL_W-1:0] SEL_IN   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OUT  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

  typedef struct packed {
    logic ldIn;
    logic cdVal;
    logic setIbf;
    logic clrIbf;
    logic ldOut;
    logic setObf;
    logic clrObf;
    logic hostRdStat;
  } mbxStrobes_t;
endpackage

// File: rtl/host_mailbox_ctrl.sv
module host_mailbox_ctrl
  import host_mailbox_pkg::*;
(
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              hostStb,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [SEL_W-1:0]  locSel,
  input  logic              locRd,
  input  logic              locWr,
  output logic              hostHit,
  output logic              hostRdHit,
  output mbxStrobes_t       stb
);
  logic upperMatch;
  logic lowerMatch;
  logic hostWrHit;

  assign upperMatch = (hostAddr[ADDR_W-1:3] == baseAddr[ADDR_W-1:3]);
  assign lowerMatch = (hostAddr[1:0] == baseAddr[1:0]);
  assign hostHit    = hostStb && upperMatch && lowerMatch;
  assign hostWrHit  = hostHit && hostWr;
  assign hostRdHit  = hostHit && !hostWr;

  always_comb begin
    stb            = '0;
    stb.ldIn       = hostWrHit;
    stb.cdVal      = hostAddr[2];
    stb.setIbf     = hostWrHit;
    stb.clrIbf     = locRd && (locSel == SEL_IN);
    stb.ldOut      = locWr && (locSel == SEL_OUT);
    stb.setObf     = locWr && (locSel == SEL_OUT);
    stb.hostRdStat = hostAddr[2];
    stb.clrObf     = hostRdHit && !hostAddr[2];
  end
endmodule

// File: rtl/host_mailbox_dpath.sv
module host_mailbox_dpath
  import host_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobes_t       stb,
  input  logic              hostRdHit,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] locWdata,
  input  logic [SEL_W-1:0]  locSel,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] locRdata,
  output logic [DATA_W-1:0] inReg,
  output logic [DATA_W-1:0] outReg,
  output logic [DATA_W-1:0] statByte
);
  logic ibf;
  logic obf;
  logic cmdFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg   <= '0;
      outReg  <= '0;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      cmdFlag <= 1'b0;
    end else begin
      if (stb.ldIn) begin
        inReg   <= hostWdata;
        cmdFlag <= stb.cdVal;
      end
      if (stb.ldOut) outReg <= locWdata;
      if (stb.setIbf)      ibf <= 1'b1;
      else if (stb.clrIbf) ibf <= 1'b0;
      if (stb.setObf)      obf <= 1'b1;
      else if (stb.clrObf) obf <= 1'b0;
    end
  end

  always_comb begin
    statByte         = '0;
    statByte[ST_OBF] = obf;
    statByte[ST_IBF] = ibf;
    statByte[ST_CD]  = cmdFlag;
  end

  always_comb begin
    if (!hostRdHit)          hostRdata = '0;
    else if (stb.hostRdStat) hostRdata = statByte;
    else                     hostRdata = outReg;
  end

  always_comb begin
    case (locSel)
      SEL_IN:   locRdata = inReg;
      SEL_OUT:  locRdata = outReg;
      SEL_STAT: locRdata = statByte;
      default:  locRdata = '0;
    endcase
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import host_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              hostStb,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRdValid,
  input  logic [SEL_W-1:0]  locSel,
  input  logic              locRd,
  input  logic              locWr,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] locRdata
);
  mbxStrobes_t       stb;
  logic              hostHit;
  logic              hostRdHit;
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] statByte;

  host_mailbox_ctrl u_ctrl (
    .baseAddr (baseAddr),
    .hostStb  (hostStb),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .locSel   (locSel),
    .locRd    (locRd),
    .locWr    (locWr),
    .hostHit  (hostHit),
    .hostRdHit(hostRdHit),
    .stb      (stb)
  );

  host_mailbox_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostRdHit(hostRdHit),
    .hostWdata(hostWdata),
    .locWdata (locWdata),
    .locSel   (locSel),
    .hostRdata(hostRdata),
    .locRdata (locRdata),
    .inReg    (inReg),
    .outReg   (outReg),
    .statByte (statByte)
  );

  assign hostRdValid = hostRdHit;
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk
  import host_mailbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              hostStb,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic [DATA_W-1:0] hostRdata,
  input logic              hostRdValid,
  input logic [SEL_W-1:0]  locSel,
  input logic              locRd,
  input logic              locWr,
  input logic [DATA_W-1:0] inReg,
  input logic [DATA_W-1:0] outReg,
  input logic [DATA_W-1:0] statByte
);
  logic chkHit;
  assign chkHit = hostStb && (hostAddr[15:3] == baseAddr[15:3]) &&
                  (hostAddr[1:0] == baseAddr[1:0]);

  assert_in_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chkHit && hostWr) |=> (inReg == $past(hostWdata)));

  assert_cd_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chkHit && hostWr) |=> (statByte[ST_CD] == $past(hostAddr[2])));

  assert_ibf_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chkHit && hostWr) |=> statByte[ST_IBF]);

  assert_obf_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (locWr && locSel == SEL_OUT) |=> statByte[ST_OBF]);

  assert_stat_read_keeps_obf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chkHit && !hostWr && hostAddr[2] && statByte[ST_OBF]) |=> statByte[ST_OBF]);

  assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostStb && !hostWr) |-> (hostRdValid == chkHit));

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!chkHit) |-> (!hostRdValid && hostRdata == '0));

  assert_miss_no_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!chkHit && !locRd && !locWr) |=> ($stable(inReg) && $stable(outReg) && $stable(statByte)));

  assert_stat_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[7:4] == 4'd0) && (statByte[2] == 1'b0));
endmodule

bind host_mailbox host_mailbox_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .baseAddr   (baseAddr),
  .hostStb    (hostStb),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWdata  (hostWdata),
  .hostRdata  (hostRdata),
  .hostRdValid(hostRdValid),
  .locSel     (locSel),
  .locRd      (locRd),
  .locWr      (locWr),
  .inReg      (inReg),
  .outReg     (outReg),
  .statByte   (statByte)
);

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baseAddr = 16'h0CA2;
  logic        hostStb = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        hostRdValid;
  logic [1:0]  locSel = '0;
  logic        locRd = 1'b0;
  logic        locWr = 1'b0;
  logic [7:0]  locWdata = '0;
  logic [7:0]  locRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  host_mailbox u_host_mailbox (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr),
    .hostStb(hostStb), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRdValid(hostRdValid),
    .locSel(locSel), .locRd(locRd), .locWr(locWr),
    .locWdata(locWdata), .locRdata(locRdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    hostStb = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostStb = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    hostStb = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1;
    d = hostRdata; v = hostRdValid;
    @(negedge clk);
    hostStb = 1'b0;
  endtask

  task automatic locRead(input logic [1:0] s, input logic strobe, output logic [7:0] d);
    @(negedge clk);
    locSel = s; locRd = strobe;
    #1;
    d = locRdata;
    @(negedge clk);
    locRd = 1'b0;
  endtask

  task automatic locWrite(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    locSel = s; locWr = 1'b1; locWdata = d;
    @(negedge clk);
    locWr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic test_reset();
    logic [7:0] d;
    locRead(2'd0, 1'b0, d); check("R1 inbound", d, 8'h00);
    locRead(2'd1, 1'b0, d); check("R1 outbound", d, 8'h00);
    locRead(2'd2, 1'b0, d); check("R1 status", d, 8'h00);
  endtask

  task automatic test_data_write();
    logic [7:0] d; logic v;
    hostWrite(16'h0CA2, 8'h5A);
    locRead(2'd2, 1'b0, d); check("R4 R6 status after data write", d, 8'h02);
    hostRead(16'h0CA6, d, v);
    check("R5 status read valid", {7'd0, v}, 8'h01);
    check("R5 status read data", d, 8'h02);
    locRead(2'd0, 1'b1, d); check("R3 inbound byte", d, 8'h5A);
    locRead(2'd2, 1'b0, d); check("R6 inbound flag cleared", d, 8'h00);
  endtask

  task automatic test_cmd_overwrite();
    logic [7:0] d;
    hostWrite(16'h0CA6, 8'hC3);
    locRead(2'd2, 1'b0, d); check("R4 command marker", d, 8'h0A);
    hostWrite(16'h0CA2, 8'h11);
    locRead(2'd2, 1'b0, d); check("R4 marker back to data", d, 8'h02);
    locRead(2'd0, 1'b1, d); check("R3 overwrite when full", d, 8'h11);
  endtask

  task automatic test_outbound();
    logic [7:0] d; logic v;
    locWrite(2'd1, 8'h77);
    locRead(2'd2, 1'b0, d); check("R7 outbound flag set", d, 8'h01);
    hostRead(16'h0CA6, d, v); check("R7 status read", d, 8'h01);
    locRead(2'd2, 1'b0, d); check("R7 status read keeps flag", d, 8'h01);
    hostRead(16'h0CA2, d, v);
    check("R5 outbound read", d, 8'h77);
    check("R5 outbound read valid", {7'd0, v}, 8'h01);
    locRead(2'd2, 1'b0, d); check("R7 flag cleared by host read", d, 8'h00);
  endtask

  task automatic test_miss();
    logic [7:0] d; logic v;
    hostWrite(16'h0CA3, 8'hEE);
    hostWrite(16'h0CAA, 8'hEE);
    hostWrite(16'h1CA2, 8'hEE);
    locRead(2'd0, 1'b0, d); check("R8 R2 inbound unchanged", d, 8'h11);
    locRead(2'd2, 1'b0, d); check("R8 status unchanged", d, 8'h00);
    locWrite(2'd1, 8'h33);
    hostRead(16'h0CA3, d, v);
    check("R8 miss rdata", d, 8'h00);
    check("R8 miss valid", {7'd0, v}, 8'h00);
    locRead(2'd2, 1'b0, d); check("R8 miss read keeps outbound flag", d, 8'h01);
    hostRead(16'h0CA2, d, v); check("R7 drain", d, 8'h33);
  endtask

  task automatic test_local_port();
    logic [7:0] d;
    locWrite(2'd2, 8'hFF);
    locRead(2'd2, 1'b0, d); check("R9 status read-only", d, 8'h00);
    locWrite(2'd0, 8'h99);
    locRead(2'd0, 1'b0, d); check("R9 inbound not locally writable", d, 8'h11);
    locWrite(2'd3, 8'h99);
    locRead(2'd3, 1'b0, d); check("R9 select 3 reads zero", d, 8'h00);
    locRead(2'd1, 1'b0, d); check("R9 outbound read-back", d, 8'h33);
  endtask

  task automatic test_collisions();
    logic [7:0] d;
    @(negedge clk);
    locSel = 2'd1; locWr = 1'b1; locWdata = 8'h44;
    hostStb = 1'b1; hostWr = 1'b0; hostAddr = 16'h0CA2;
    #1; d = hostRdata;
    check("R7 same-cycle read sees old byte", d, 8'h33);
    @(negedge clk);
    locWr = 1'b0; hostStb = 1'b0;
    locRead(2'd2, 1'b0, d); check("R7 set wins over clear", d, 8'h01);
    @(negedge clk);
    locSel = 2'd0; locRd = 1'b1;
    hostStb = 1'b1; hostWr = 1'b1; hostAddr = 16'h0CA2; hostWdata = 8'h21;
    @(negedge clk);
    locRd = 1'b0; hostStb = 1'b0; hostWr = 1'b0;
    locRead(2'd2, 1'b0, d); check("R6 set wins over clear", d, 8'h03);
  endtask

  task automatic test_new_base();
    logic [7:0] d;
    baseAddr = 16'hF0F1;
    hostWrite(16'h0CA2, 8'h55);
    locRead(2'd0, 1'b0, d); check("R2 old base ignored", d, 8'h21);
    hostWrite(16'hF0F5, 8'h42);
    locRead(2'd0, 1'b0, d); check("R2 new base hit", d, 8'h42);
    locRead(2'd2, 1'b0, d); check("R4 command at new base", d, 8'h0B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_data_write();
    test_cmd_overwrite();
    test_outbound();
    test_miss();
    test_local_port();
    test_collisions();
    test_new_base();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule